// File: doc/BRIEF.md
# Edge-Locking Pulse Stretcher

This block turns short or bouncing logic activity into an output level that stays put long enough to be seen on an indicator. It is also suitable for cleaning up a pushbutton. The input is asynchronous. It passes through a synchroniser and is then compared with the current output.

When the two differ and the block is armed, the output takes the new level on the next clock. A hold-off window of a fixed number of clock cycles then starts, and any input movement during that window is disregarded. When the window closes, the block re-arms and compares the input with the output once more. A mismatch found at that point counts as a fresh edge.

Unlike a settle-then-switch debouncer, the output reacts to the first edge and locks out afterwards. The hold-off length is a parameter, sized by default for a dead time of a few hundred milliseconds.

Top module: `edge_lockout_stretcher`

## Requirements
- R1: A synchronous reset drives `stretchOut` to 0 and `busy` to 0, and leaves the block armed, on the first clock edge at which `rst` is sampled high.
- R2: While armed, a rising edge on the synchronised input sets `stretchOut` to 1 exactly one clock after the synchronised input changes.
- R3: While armed, a falling edge on the synchronised input clears `stretchOut` to 0 exactly one clock after the synchronised input changes.
- R4: After each accepted edge, `busy` is high for exactly HOLD_CYCLES consecutive clock cycles. The first of these cycles is the one in which `stretchOut` takes its new level.
- R5: While `busy` is high, input changes do not alter `stretchOut` and do not restart or lengthen the hold-off window.
- R6: Once re-armed, the block stays idle with `stretchOut` unchanged while the synchronised input equals the output. If the two differ, `stretchOut` takes the input level on the first clock after `busy` falls.
- R7: A pulse on `asyncIn` lasting one clock still produces an output level lasting HOLD_CYCLES+1 clocks.
- R8: `asyncIn` passes through SYNC_STAGES (default 2) flip-flops before comparison. With the defaults, a change on `asyncIn` reaches `stretchOut` on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| asyncIn | input | 1 | Asynchronous level to be stretched |
| stretchOut | output | 1 | Stretched output level |
| busy | output | 1 | High during the hold-off window |

## Verification
The bench builds the block with HOLD_CYCLES set to 20 and the default two-stage synchroniser. This makes the whole hold-off window, and the re-arm point that follows it, reachable in a few dozen cycles, so `busy` can be counted cycle by cycle. With a window that short, the bench can also toggle the input inside the window, end on a level that differs from the output, and apply a one-cycle pulse. It then checks the exact re-arm edge and the total stretched length.

// File: rtl/pulse_hold_pkg.sv
package pulse_hold_pkg;
  // Strobes sent from the control decision to the hold datapath
  typedef struct packed {
    logic acceptEdge;  // load new output level and reload the hold counter
    logic countDown;   // decrement the hold counter
  } holdStrobe_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [SYNC_STAGES-1:0] stageQ;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stageQ <= '0;
        else     stageQ <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stageQ <= '0;
        else     stageQ <= {stageQ[SYNC_STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stageQ[SYNC_STAGES-1];
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import pulse_hold_pkg::*;
(
  input  logic        syncLevel,
  input  logic        outLevel,
  input  logic        holdZero,
  output holdStrobe_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.acceptEdge = holdZero && (syncLevel != outLevel);
    strobes.countDown  = !holdZero;
  end
endmodule

// File: rtl/hold_datapath.sv
module hold_datapath
  import pulse_hold_pkg::*;
#(
  parameter int HOLD_CYCLES = 50_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        syncLevel,
  input  holdStrobe_t strobes,
  output logic        outLevel,
  output logic        holdZero
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCount <= '0;
      outLevel  <= 1'b0;
    end else if (strobes.acceptEdge) begin
      holdCount <= HOLD_VAL;
      outLevel  <= syncLevel;
    end else if (strobes.countDown) begin
      holdCount <= holdCount - CNT_W'(1);
    end
  end

  assign holdZero = (holdCount == '0);

  // R4: an accepted edge reloads the full window
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.acceptEdge |=> (holdCount == HOLD_VAL));

  // R5: inside the window the counter only ever steps down by one
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (holdCount != '0) |=> (holdCount == $past(holdCount) - CNT_W'(1)));
endmodule

// File: rtl/edge_lockout_stretcher.sv
module edge_lockout_stretcher
  import pulse_hold_pkg::*;
#(
  parameter int HOLD_CYCLES = 50_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic stretchOut,
  output logic busy
);
  logic        syncLevel;
  logic        outLevel;
  logic        holdZero;
  holdStrobe_t strobes;

  edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(asyncIn),
    .syncOut(syncLevel)
  );

  hold_ctrl u_ctrl (
    .syncLevel(syncLevel),
    .outLevel (outLevel),
    .holdZero (holdZero),
    .strobes  (strobes)
  );

  hold_datapath #(.HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .syncLevel(syncLevel),
    .strobes  (strobes),
    .outLevel (outLevel),
    .holdZero (holdZero)
  );

  assign stretchOut = outLevel;
  assign busy       = !holdZero;

  // R2/R3: armed mismatch is followed one clock later
  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && syncLevel != stretchOut) |=> (stretchOut == $past(syncLevel) && busy));

  // R5: the output is frozen while busy
  p_lockout_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(stretchOut));

  // R6: armed and matching means nothing moves
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && syncLevel == stretchOut) |=> ($stable(stretchOut) && !busy));
endmodule

// File: tb/edge_lockout_stretcher_test.sv
module edge_lockout_stretcher_test;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic stretchOut;
  logic busy;
  int   nChecks = 0;
  int   nFails  = 0;

  always #2 clk = ~clk;

  edge_lockout_stretcher #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .asyncIn   (din),
    .stretchOut(stretchOut),
    .busy      (busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts busy cycles, the current sample included
  task automatic measureBusy(output int n);
    n = busy ? 1 : 0;
    for (int i = 0; i < 4 * HOLD && busy; i++) begin
      tick();
      if (busy) n++;
    end
  endtask

  task automatic testReset();
    rst = 1'b1; din = 1'b0;
    tick(); tick();
    check("R1 out after reset", stretchOut, 0);
    check("R1 busy after reset", busy, 0);
    rst = 1'b0;
    tick(); tick(); tick();
    check("R1 armed and idle", busy, 0);
  endtask

  task automatic testRise();
    int n;
    din = 1'b1;
    tick(); tick();
    check("R8 not yet after two edges", stretchOut, 0);
    tick();
    check("R2 rise after third edge", stretchOut, 1);
    check("R4 busy with rise", busy, 1);
    measureBusy(n);
    check("R4 busy length after rise", n, HOLD);
    check("R6 idle keeps level", stretchOut, 1);
  endtask

  task automatic testFall();
    int n;
    din = 1'b0;
    tick(); tick();
    check("R3 not yet", stretchOut, 1);
    tick();
    check("R3 fall after third edge", stretchOut, 0);
    measureBusy(n);
    check("R4 busy length after fall", n, HOLD);
  endtask

  task automatic testIgnore();
    int n;
    int moved = 0;
    din = 1'b1;
    tick(); tick(); tick();
    check("R2 rise before bounce", stretchOut, 1);
    n = 1;
    for (int i = 0; i < HOLD / 2; i++) begin
      din = ~din;
      tick();
      if (stretchOut != 1) moved++;
      if (busy) n++;
    end
    din = 1'b1;
    for (int i = 0; i < 4 * HOLD && busy; i++) begin
      tick();
      if (stretchOut != 1) moved++;
      if (busy) n++;
    end
    check("R5 bounce ignored", moved, 0);
    check("R5 window not extended", n, HOLD);
    tick(); tick(); tick();
    check("R6 no retrigger when matching", busy, 0);
  endtask

  task automatic testRearm();
    din = 1'b0;
    tick(); tick(); tick();
    check("R3 fall before rearm test", stretchOut, 0);
    din = 1'b1;
    for (int i = 0; i < 4 * HOLD && busy; i++) tick();
    check("R6 still held at window end", stretchOut, 0);
    tick();
    check("R6 mismatch taken after rearm", stretchOut, 1);
    check("R6 new window started", busy, 1);
    for (int i = 0; i < 4 * HOLD && busy; i++) tick();
  endtask

  task automatic testShortPulse();
    int hi = 0;
    int n;
    din = 1'b0;
    tick(); tick(); tick();
    for (int i = 0; i < 4 * HOLD && busy; i++) tick();
    check("R7 start low", stretchOut, 0);
    din = 1'b1;
    tick();
    din = 1'b0;
    tick(); tick();
    check("R7 pulse seen", stretchOut, 1);
    for (int i = 0; i < 4 * HOLD && stretchOut; i++) begin
      hi++;
      tick();
    end
    check("R7 stretched length", hi, HOLD + 1);
    check("R7 back low", stretchOut, 0);
    measureBusy(n);
    check("R4 busy length after return", n, HOLD);
  endtask

  task automatic testMidReset();
    din = 1'b1;
    tick(); tick(); tick();
    check("R2 rise before reset", stretchOut, 1);
    tick();
    rst = 1'b1; din = 1'b0;
    tick();
    check("R1 reset clears out", stretchOut, 0);
    check("R1 reset clears busy", busy, 0);
    rst = 1'b0;
    tick(); tick(); tick();
    check("R1 armed idle after reset", busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testRise();
    testFall();
    testIgnore();
    testRearm();
    testShortPulse();
    testMidReset();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule